// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands of parameterised width and says whether the first is larger than, equal to, or smaller than the second. It is purely combinational. It is built as a chain of one-bit cells. The cell for the most significant bit sees the decision carried in from above. Each lower cell either passes that decision on or, while the operands still match, settles it from its own bit pair.

The decision carried in from above enters through three flag inputs, and the decision after the lowest bit leaves through three flag outputs. To compare a word on its own, drive the inputs with "equal so far" (greater 0, equal 1, less 0). To compare a wider word, split it across several instances and feed the outputs of the more significant instance into the inputs of the less significant one. A parameter selects how the final equality flag is formed: either from the last cell of the chain, or from a flat reduction over all bit pairs, which is shallower.

Top module: `mag_cmp_chain`

## Requirements
- R1: With cascade inputs (greater,equal,less) = (0,1,0) and A > B, the outputs are (1,0,0).
- R2: With cascade inputs (0,1,0) and A = B, the outputs are (0,1,0). This holds for both equality variants (EQ_TREE = 0 or 1).
- R3: With cascade inputs (0,1,0) and A < B, the outputs are (0,0,1).
- R4: Whenever exactly one cascade input is high, exactly one output is high.
- R5: With cascade inputs (1,0,0), the outputs are (1,0,0) for every A and B.
- R6: With cascade inputs (0,0,1), the outputs are (0,0,1) for every A and B.
- R7: Two instances chained high-to-low compare the concatenated words exactly as one wide instance would.
- R8: With cascade inputs (0,0,0), all outputs are 0 for every A and B.
- R9: For any cascade input pattern, the outputs are as follows. The greater output is greater_in OR (equal_in AND A>B). The equal output is equal_in AND A=B. The less output is less_in OR (equal_in AND A<B).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | WIDTH | First unsigned operand |
| b_op | input | WIDTH | Second unsigned operand |
| gt_in | input | 1 | Carried-in decision: more significant part of A is greater |
| eq_in | input | 1 | Carried-in decision: more significant parts equal so far |
| lt_in | input | 1 | Carried-in decision: more significant part of A is less |
| gt_out | output | 1 | A greater than B, after the lowest bit |
| eq_out | output | 1 | A equal to B, after the lowest bit |
| lt_out | output | 1 | A less than B, after the lowest bit |

## Verification
The one-hot check on the outputs applies only when exactly one cascade input is high. Patterns with several inputs high, or none, are legal but carry no one-hot promise; the other assertions hold for every pattern. The stimulus covers both cases on purpose. A narrow instance is swept over every operand pair together with all eight cascade patterns. The wide and chained instances get random operands with the neutral pattern, plus directed extremes that differ only in the top or the bottom bit.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

   // Decision carried along the chain, most significant side first.
   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cmp_flags_t;

   localparam cmp_flags_t CMP_NEUTRAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
   import mag_cmp_pkg::*;
(
   input  logic       a_bit,
   input  logic       b_bit,
   input  cmp_flags_t up,
   output cmp_flags_t dn
);

   logic a_wins;
   logic b_wins;
   logic same;

   assign a_wins = a_bit & ~b_bit;
   assign b_wins = ~a_bit & b_bit;
   assign same   = ~(a_bit ^ b_bit);

   // A decision made above is sticky; only an open "equal so far" may change.
   assign dn.gt = up.gt | (up.eq & a_wins);
   assign dn.lt = up.lt | (up.eq & b_wins);
   assign dn.eq = up.eq & same;

   always_comb begin
      // R9: equality can only survive a cell that received it
      a_r9_eq_needs_up : assert (!dn.eq || up.eq)
         else $error("slice equality raised without incoming equality");
   end

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
   import mag_cmp_pkg::*;
#(
   parameter int WIDTH   = 16,
   parameter bit EQ_TREE = 1'b0
) (
   input  logic [WIDTH-1:0] a_op,
   input  logic [WIDTH-1:0] b_op,
   input  logic             gt_in,
   input  logic             eq_in,
   input  logic             lt_in,
   output logic             gt_out,
   output logic             eq_out,
   output logic             lt_out
);

   localparam int TOP = WIDTH;

   initial begin
      a_width_legal : assert (WIDTH >= 1)
         else $error("WIDTH must be at least 1");
   end

   // stage[TOP] is the carried-in decision, stage[0] the result after bit 0.
   cmp_flags_t [TOP:0] stage;

   assign stage[TOP] = '{gt: gt_in, eq: eq_in, lt: lt_in};

   for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_bit
      mag_cmp_slice u_slice (
         .a_bit (a_op[i]),
         .b_bit (b_op[i]),
         .up    (stage[i+1]),
         .dn    (stage[i])
      );
   end

   assign gt_out = stage[0].gt;
   assign lt_out = stage[0].lt;

   logic eq_ripple;
   assign eq_ripple = stage[0].eq;

   if (EQ_TREE) begin : g_eq_tree
      logic eq_flat;
      assign eq_flat = eq_in & (&(a_op ~^ b_op));
      assign eq_out  = eq_flat;

      always_comb begin
         // R2: flat reduction and ripple must agree on equality
         a_r2_tree_matches_chain : assert (eq_flat == eq_ripple)
            else $error("flat equality disagrees with chain");
      end
   end else begin : g_eq_ripple
      assign eq_out = eq_ripple;
   end

   logic [2:0] flags_in;
   logic [2:0] flags_out;
   assign flags_in  = {gt_in, eq_in, lt_in};
   assign flags_out = {gt_out, eq_out, lt_out};

   always_comb begin
      // R4: one-hot decision in gives one-hot decision out
      if ($countones(flags_in) == 1)
         a_r4_onehot_kept : assert ($countones(flags_out) == 1)
            else $error("one-hot cascade input produced non one-hot result");
      // R5: a carried-in greater decision is never lost
      if (gt_in)
         a_r5_gt_sticky : assert (gt_out)
            else $error("greater decision dropped");
      // R6: a carried-in less decision is never lost
      if (lt_in)
         a_r6_lt_sticky : assert (lt_out)
            else $error("less decision dropped");
      // R8: no decision in, no decision out
      if (flags_in == 3'b000)
         a_r8_idle_quiet : assert (flags_out == 3'b000)
            else $error("outputs raised with all cascade inputs low");
   end

endmodule

// File: tb/mag_cmp_chain_tb.sv
module mag_cmp_chain_tb;

   localparam int WW = 16;
   localparam int NW = 3;
   localparam int HW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;   // 250 MHz

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // wide instance, ripple equality
   logic [WW-1:0] wa, wb;
   logic wgi, wei, wli, wgo, weo, wlo;
   mag_cmp_chain #(.WIDTH(WW), .EQ_TREE(1'b0)) u_dut (
      .a_op(wa), .b_op(wb), .gt_in(wgi), .eq_in(wei), .lt_in(wli),
      .gt_out(wgo), .eq_out(weo), .lt_out(wlo));

   // narrow instance, flat equality, swept exhaustively
   logic [NW-1:0] na, nb;
   logic ngi, nei, nli, ngo, neo, nlo;
   mag_cmp_chain #(.WIDTH(NW), .EQ_TREE(1'b1)) u_small (
      .a_op(na), .b_op(nb), .gt_in(ngi), .eq_in(nei), .lt_in(nli),
      .gt_out(ngo), .eq_out(neo), .lt_out(nlo));

   // two chained halves fed from the wide operands
   logic hg, he, hl, lgo, leo, llo;
   mag_cmp_chain #(.WIDTH(HW)) u_hi (
      .a_op(wa[WW-1:HW]), .b_op(wb[WW-1:HW]), .gt_in(1'b0), .eq_in(1'b1), .lt_in(1'b0),
      .gt_out(hg), .eq_out(he), .lt_out(hl));
   mag_cmp_chain #(.WIDTH(HW)) u_lo (
      .a_op(wa[HW-1:0]), .b_op(wb[HW-1:0]), .gt_in(hg), .eq_in(he), .lt_in(hl),
      .gt_out(lgo), .eq_out(leo), .lt_out(llo));

   function automatic logic [2:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] cin);
      logic g, e, l;
      g = cin[2] | (cin[1] & (a > b));
      e = cin[1] & (a == b);
      l = cin[0] | (cin[1] & (a < b));
      return {g, e, l};
   endfunction

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic wide_case(input logic [WW-1:0] a, input logic [WW-1:0] b);
      logic [2:0] e;
      @(negedge clk);
      wa = a; wb = b; wgi = 1'b0; wei = 1'b1; wli = 1'b0;
      #1;
      e = model(32'(a), 32'(b), 3'b010);
      check(e[2] ? "R1" : (e[1] ? "R2" : "R3"), {wgo, weo, wlo}, e);
      check("R4", {2'b00, ($countones({wgo, weo, wlo}) == 1)}, 3'b001);
      check("R7", {lgo, leo, llo}, e);
   endtask

   initial begin
      wa = '0; wb = '0; wgi = 1'b0; wei = 1'b0; wli = 1'b0;
      na = '0; nb = '0; ngi = 1'b0; nei = 1'b0; nli = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk); #1;
      // R8: idle state after reset, all cascade inputs low
      check("R8", {wgo, weo, wlo}, 3'b000);

      // exhaustive narrow sweep with every cascade pattern
      for (int c = 0; c < 8; c++) begin
         for (int a = 0; a < (1 << NW); a++) begin
            for (int b = 0; b < (1 << NW); b++) begin
               logic [2:0] e;
               string tag;
               @(negedge clk);
               na = NW'(a); nb = NW'(b);
               {ngi, nei, nli} = 3'(c);
               #1;
               e = model(32'(a), 32'(b), 3'(c));
               case (c)
                  3'b010:  tag = e[2] ? "R1" : (e[1] ? "R2" : "R3");
                  3'b100:  tag = "R5";
                  3'b001:  tag = "R6";
                  3'b000:  tag = "R8";
                  default: tag = "R9";
               endcase
               check(tag, {ngo, neo, nlo}, e);
            end
         end
      end

      // directed wide corners
      wide_case('0, '0);
      wide_case('1, '1);
      wide_case({1'b1, {(WW-1){1'b0}}}, {1'b0, {(WW-1){1'b1}}});
      wide_case({1'b0, {(WW-1){1'b1}}}, {1'b1, {(WW-1){1'b0}}});
      wide_case(16'h00FF, 16'h00FE);
      wide_case(16'h1234, 16'h1235);
      wide_case(16'hAB00, 16'hAA00);

      // random wide vectors, fixed seed
      void'($urandom(32'd4242));
      for (int k = 0; k < 2000; k++) begin
         logic [WW-1:0] ra, rb;
         ra = WW'($urandom());
         rb = (k % 4 == 0) ? ra : WW'($urandom());
         if (k % 7 == 0) rb = ra ^ WW'(1 << (k % WW));
         wide_case(ra, rb);
      end

      // wide sticky decisions carried in from above
      @(negedge clk);
      wa = 16'h0001; wb = 16'hFFFF; {wgi, wei, wli} = 3'b100; #1;
      check("R5", {wgo, weo, wlo}, 3'b100);
      @(negedge clk);
      wa = 16'hFFFF; wb = 16'h0000; {wgi, wei, wli} = 3'b001; #1;
      check("R6", {wgo, weo, wlo}, 3'b001);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule